// File: doc/BRIEF.md
# Multi-Mode 8x8 Hardware Multiplier

This block multiplies two operand bytes and returns a 16-bit product a fixed two clock cycles after a start strobe is accepted. A 3-bit operation select picks how the operands are read and whether the result is shifted. The operands can be read as both unsigned, both two's-complement signed, or a signed first operand with an unsigned second operand. Each of these can also run as a fractional variant, in which the product is shifted left by one bit.

The product is returned as separate high and low bytes, so a core can steer them into a fixed register pair. Zero and Carry flags come out alongside the product, and they are the only flags a multiply produces. The result and the flags stay where they are until the next accepted start. A strobe that arrives while a multiply is in flight is dropped. Writing the product back into a register file and decoding instructions are left to the surrounding core.

Top module: `mulx_unit`

## Requirements
- R1: A start accepted on a clock edge (start_i high while idle) makes done_o high for exactly one cycle, during the second cycle after that edge. The new result and flags are visible in the same cycle.
- R2: With op_sel_i = 3'b000, both operands are unsigned and the result is opa_i × opb_i.
- R3: With op_sel_i = 3'b001, both operands are two's-complement signed and the result is the low 16 bits of the signed product.
- R4: With op_sel_i = 3'b010, opa_i is sign-extended and opb_i is zero-extended before multiplying. The result is the low 16 bits of that product.
- R5: When op_sel_i[2] = 1, the block forms the product selected by op_sel_i[1:0] and then shifts it left by one bit, dropping the top bit and filling bit 0 with zero.
- R6: flag_c_o equals bit 15 of the product before any fractional shift.
- R7: flag_z_o is 1 exactly when the final 16-bit result, after any shift, is 0x0000.
- R8: prod_hi_o, prod_lo_o, flag_z_o and flag_c_o hold their values until the next accepted start delivers a new result. Operand and select changes without an accepted start have no effect on them.
- R9: A start_i that is high during the cycle after an accepted start (while busy) is ignored. It produces no second done_o and does not alter the result.
- R10: A synchronous active-high rst clears the result, both flags, done_o and the busy state. An operation in flight when rst is applied never completes.
- R11: When op_sel_i[1:0] = 2'b11, the operands are treated as unsigned (3'b011 behaves as 3'b000 and 3'b111 behaves as 3'b100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_sel_i | input | 3 | Operation select: bit 2 selects fractional, bits 1:0 select operand kind (00 UU, 01 SS, 10 SU, 11 UU) |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| flag_z_o | output | 1 | Zero flag of the last result |
| flag_c_o | output | 1 | Carry flag (pre-shift bit 15) of the last result |

## Verification
Some properties are checked on every cycle. These are the two-cycle latency from an accepted start to done, the single-cycle width of done, the fact that busy lasts one cycle whatever start does, and that results and flags are stable outside done. The same checks cover zero and carry consistency with the presented result for integer modes, the cleared bit 0 in fractional modes, and the cleared state after reset. The arithmetic itself can only be shown by the bench's operand scenarios. These include the sign and zero extension in the mixed mode, the dropped top bit in fractional modes, and the reserved kind code. The same is true of a strobe held through the busy cycle and of a reset that kills an operation in flight.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
   typedef enum logic [1:0] {
      KIND_UU  = 2'b00,
      KIND_SS  = 2'b01,
      KIND_SU  = 2'b10,
      KIND_RSV = 2'b11
   } mul_kind_e;

   function automatic logic kind_a_signed(input mul_kind_e k);
      return (k == KIND_SS) || (k == KIND_SU);
   endfunction

   function automatic logic kind_b_signed(input mul_kind_e k);
      return (k == KIND_SS);
   endfunction
endpackage

// File: rtl/mulx_operand_ext.sv
module mulx_operand_ext #(
   parameter int OPW = 8
) (
   input  logic [OPW-1:0]   val_i,
   input  logic             sgn_i,
   output logic [2*OPW-1:0] ext_o
);
   logic fill;
   assign fill  = sgn_i & val_i[OPW-1];
   assign ext_o = {{OPW{fill}}, val_i};
endmodule

// File: rtl/mulx_prod_array.sv
module mulx_prod_array #(
   parameter int OPW  = 8,
   parameter int ARCH = 1
) (
   input  logic [2*OPW-1:0] a_i,
   input  logic [2*OPW-1:0] b_i,
   output logic [2*OPW-1:0] p_o
);
   localparam int PW = 2 * OPW;

   generate
      if (ARCH == 0) begin : g_inferred
         assign p_o = a_i * b_i;
      end else begin : g_rows
         logic [PW-1:0] row [PW];
         for (genvar i = 0; i < PW; i++) begin : g_pp
            assign row[i] = b_i[i] ? (a_i << i) : '0;
         end
         always_comb begin
            p_o = '0;
            for (int k = 0; k < PW; k++) begin
               p_o = p_o + row[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mulx_finish.sv
module mulx_finish #(
   parameter int OPW = 8
) (
   input  logic [2*OPW-1:0] prod_i,
   input  logic             frac_i,
   output logic [2*OPW-1:0] res_o,
   output logic             c_o,
   output logic             z_o
);
   localparam int PW = 2 * OPW;

   assign res_o = frac_i ? {prod_i[PW-2:0], 1'b0} : prod_i;
   assign c_o   = prod_i[PW-1];
   assign z_o   = (res_o == '0);
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
   import mulx_pkg::*;
#(
   parameter int OPW  = 8,
   parameter int ARCH = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start_i,
   input  logic [2:0]     op_sel_i,
   input  logic [OPW-1:0] opa_i,
   input  logic [OPW-1:0] opb_i,
   output logic           done_o,
   output logic [OPW-1:0] prod_hi_o,
   output logic [OPW-1:0] prod_lo_o,
   output logic           flag_z_o,
   output logic           flag_c_o
);
   localparam int PW = 2 * OPW;

   generate
      if (OPW < 2) begin : g_bad_width
         $error("mulx_unit: OPW must be at least 2");
      end
      if (ARCH < 0 || ARCH > 1) begin : g_bad_arch
         $error("mulx_unit: ARCH must be 0 or 1");
      end
   endgenerate

   // stage 1: operand capture
   logic           busy_q;
   logic           accept;
   logic [OPW-1:0] a_q, b_q;
   mul_kind_e      kind_q;
   logic           frac_q;

   assign accept = start_i & ~busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         kind_q <= KIND_UU;
         frac_q <= 1'b0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            a_q    <= opa_i;
            b_q    <= opb_i;
            kind_q <= mul_kind_e'(op_sel_i[1:0]);
            frac_q <= op_sel_i[2];
         end
      end
   end

   // stage 2: multiply, shape, register
   logic [PW-1:0] a_ext, b_ext, prod, shaped;
   logic          c_nxt, z_nxt;

   mulx_operand_ext #(.OPW(OPW)) u_ext_a (
      .val_i(a_q), .sgn_i(kind_a_signed(kind_q)), .ext_o(a_ext)
   );
   mulx_operand_ext #(.OPW(OPW)) u_ext_b (
      .val_i(b_q), .sgn_i(kind_b_signed(kind_q)), .ext_o(b_ext)
   );
   mulx_prod_array #(.OPW(OPW), .ARCH(ARCH)) u_prod (
      .a_i(a_ext), .b_i(b_ext), .p_o(prod)
   );
   mulx_finish #(.OPW(OPW)) u_fin (
      .prod_i(prod), .frac_i(frac_q), .res_o(shaped), .c_o(c_nxt), .z_o(z_nxt)
   );

   logic [PW-1:0] res_q;
   logic          z_q, c_q, done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         z_q    <= 1'b0;
         c_q    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy_q;
         if (busy_q) begin
            res_q <= shaped;
            z_q   <= z_nxt;
            c_q   <= c_nxt;
         end
      end
   end

   assign done_o    = done_q;
   assign prod_hi_o = res_q[PW-1:OPW];
   assign prod_lo_o = res_q[OPW-1:0];
   assign flag_z_o  = z_q;
   assign flag_c_o  = c_q;
endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
   parameter int OPW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           start_i,
   input logic           done_o,
   input logic [OPW-1:0] prod_hi_o,
   input logic [OPW-1:0] prod_lo_o,
   input logic           flag_z_o,
   input logic           flag_c_o,
   input logic           busy,
   input logic           frac
);
   p_latency_r1: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy) |=> busy ##1 done_o);

   p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
      busy |=> !busy);

   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!done_o && !$past(rst)) |-> $stable({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}));

   p_zero_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (flag_z_o == ({prod_hi_o, prod_lo_o} == '0)));

   p_carry_int_r6: assert property (@(posedge clk) disable iff (rst)
      (done_o && !frac) |-> (flag_c_o == prod_hi_o[OPW-1]));

   p_frac_lsb_r5: assert property (@(posedge clk) disable iff (rst)
      (done_o && frac) |-> !prod_lo_o[0]);

   p_reset_r10: assert property (@(posedge clk)
      rst |=> (!done_o && !busy && !flag_z_o && !flag_c_o
               && prod_hi_o == '0 && prod_lo_o == '0));
endmodule

bind mulx_unit mulx_unit_chk #(.OPW(OPW)) u_chk (
   .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
   .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
   .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
   .busy(busy_q), .frac(frac_q)
);

// File: tb/mulx_unit_tb.sv
module mulx_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_i = 1'b0;
   logic [2:0] op_sel_i = '0;
   logic [7:0] opa_i = '0, opb_i = '0;
   logic       done_o, flag_z_o, flag_c_o;
   logic [7:0] prod_hi_o, prod_lo_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   mulx_unit dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .op_sel_i(op_sel_i),
      .opa_i(opa_i), .opb_i(opb_i), .done_o(done_o),
      .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
      .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
   );

   // {op, a, b, expected result, carry, zero}
   localparam int NV = 17;
   localparam logic [36:0] VEC [NV] = '{
      {3'd0, 8'h03, 8'h05, 16'h000F, 1'b0, 1'b0},
      {3'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},
      {3'd1, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},
      {3'd1, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},
      {3'd1, 8'h80, 8'h7F, 16'hC080, 1'b1, 1'b0},
      {3'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b1, 1'b0},
      {3'd2, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},
      {3'd2, 8'h01, 8'h80, 16'h0080, 1'b0, 1'b0},
      {3'd0, 8'h00, 8'hAB, 16'h0000, 1'b0, 1'b1},
      {3'd4, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
      {3'd5, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0},
      {3'd4, 8'hFF, 8'hFF, 16'hFC02, 1'b1, 1'b0},
      {3'd6, 8'h80, 8'h80, 16'h8000, 1'b1, 1'b0},
      {3'd6, 8'hFF, 8'h01, 16'hFFFE, 1'b1, 1'b0},
      {3'd5, 8'h00, 8'h5A, 16'h0000, 1'b0, 1'b1},
      {3'd3, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},
      {3'd7, 8'hFF, 8'hFF, 16'hFC02, 1'b1, 1'b0}
   };

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3, 3'd7: return "R11";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] res();
      return {prod_hi_o, prod_lo_o};
   endfunction

   // drive a start at a falling edge; returns at the falling edge where done is due
   task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      start_i = 1'b1; op_sel_i = op; opa_i = a; opb_i = b;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R1", "done early", 32'(done_o), 32'd0);
      @(negedge clk);
      chk(done_o == 1'b1, "R1", "done on second cycle", 32'(done_o), 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10: reset state
      chk(res() == 16'h0 && !flag_z_o && !flag_c_o && !done_o, "R10", "reset state",
          {13'd0, done_o, flag_c_o, flag_z_o, res()}, 32'd0);

      // table walk: R2 R3 R4 R5 R6 R7 R11
      for (int i = 0; i < NV; i++) begin
         logic [2:0]  op  = VEC[i][36:34];
         logic [7:0]  a   = VEC[i][33:26];
         logic [7:0]  b   = VEC[i][25:18];
         logic [15:0] exp = VEC[i][17:2];
         logic        ec  = VEC[i][1];
         logic        ez  = VEC[i][0];
         issue(op, a, b);
         chk(res() == exp, tag_of(op), "product", 32'(res()), 32'(exp));
         chk(flag_c_o == ec, "R6", "carry", 32'(flag_c_o), 32'(ec));
         chk(flag_z_o == ez, "R7", "zero", 32'(flag_z_o), 32'(ez));
         @(negedge clk);
         chk(done_o == 1'b0, "R1", "done one cycle", 32'(done_o), 32'd0);
      end

      // R8: hold with operand and select churn but no start
      issue(3'd0, 8'h12, 8'h34);        // 0x03A8
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         op_sel_i = 3'(k); opa_i = 8'(k * 37); opb_i = 8'hFF - 8'(k);
      end
      @(negedge clk);
      chk(res() == 16'h03A8 && !flag_z_o && !flag_c_o && !done_o, "R8", "held result",
          {13'd0, done_o, flag_c_o, flag_z_o, res()}, 32'h03A8);

      // R9: start held high through the busy cycle with new operands
      @(negedge clk);
      start_i = 1'b1; op_sel_i = 3'd0; opa_i = 8'h02; opb_i = 8'h03;
      @(negedge clk);
      opa_i = 8'hFF; opb_i = 8'hFF;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o && res() == 16'h0006, "R9", "first result",
          {15'd0, done_o, res()}, 32'h0001_0006);
      @(negedge clk);
      chk(!done_o && res() == 16'h0006, "R9", "busy start ignored",
          {15'd0, done_o, res()}, 32'h0000_0006);
      @(negedge clk);
      chk(!done_o && res() == 16'h0006, "R9", "no late result",
          {15'd0, done_o, res()}, 32'h0000_0006);

      // R10: reset after a result clears it
      issue(3'd0, 8'hFF, 8'hFF);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(res() == 16'h0 && !flag_c_o && !flag_z_o, "R10", "reset clears result",
          {14'd0, flag_c_o, flag_z_o, res()}, 32'd0);

      // R10: reset during busy kills the operation
      @(negedge clk);
      start_i = 1'b1; op_sel_i = 3'd0; opa_i = 8'h11; opb_i = 8'h11;
      @(negedge clk);
      start_i = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!done_o && res() == 16'h0, "R10", "in-flight killed",
          {15'd0, done_o, res()}, 32'd0);
      @(negedge clk);
      chk(!done_o && res() == 16'h0, "R10", "no done after reset",
          {15'd0, done_o, res()}, 32'd0);

      // R1: back-to-back accepted starts two cycles apart
      issue(3'd1, 8'hFE, 8'h03);        // -6 -> FFFA
      chk(res() == 16'hFFFA && flag_c_o, "R1", "first of pair",
          {15'd0, flag_c_o, res()}, 32'h0001_FFFA);
      start_i = 1'b1; op_sel_i = 3'd0; opa_i = 8'h10; opb_i = 8'h10;
      @(negedge clk);
      start_i = 1'b0;
      chk(!done_o, "R1", "gap cycle", 32'(done_o), 32'd0);
      @(negedge clk);
      chk(done_o && res() == 16'h0100, "R1", "second of pair",
          {15'd0, done_o, res()}, 32'h0001_0100);

      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule